// File: doc/BRIEF.md
# Single-Parity Outer Code with Least-Reliable-Bit Correction

This block wraps a convolutional threshold decoder with an outer even-parity code. On the transmit side it passes information bits straight through. After every group of `N1` information bits it also produces one parity bit, chosen so that the group and its parity hold an even number of ones. The parity bit is presented on a separate strobe in the same cycle as the group's last information bit, so the encoder never has to stall its source.

On the receive side the block takes a stream of `N1+1` decoded bits per group. Each bit arrives with the signed checksum that the inner decoder computed while deciding it. A checksum near zero means the inner decoder was unsure about that bit. The block collects a whole group, keeping a running parity and a running pick of the least confident bit.

- If the group's parity holds, the information bits go out as received.
- If the parity fails, exactly one bit is inverted: the one whose checksum has the smallest magnitude.

The parity position is dropped from the output. Each output bit carries a flag that says whether its group was corrected.

Top module: `spc_outer_code`

## Requirements
- R1: Every information bit presented with `enc_in_valid` appears unchanged on `enc_out_bit`, with `enc_out_valid` high, one clock later.
- R2: `enc_par_valid` rises together with the output of every `N1`-th information bit since reset. At that point `enc_par_bit` equals the XOR of those `N1` bits, which gives even parity, and the count restarts.
- R3: A received group has bit index 0 first and the parity bit at index `N1` last. When the XOR of all `N1+1` bits is 0, the `N1` information bits are output in arrival order without change and `dec_out_fixed` is 0.
- R4: When the group XOR is 1, exactly one bit is inverted: the one whose checksum has the smallest magnitude. `dec_out_fixed` is 1 for every output bit of that group.
- R5: Checksum magnitude is the two's complement absolute value. The most negative code, -2^(CSW-1), counts as magnitude 2^(CSW-1), which is larger than any other value.
- R6: When several bits share the smallest magnitude, the one with the lowest index is inverted.
- R7: When the least reliable bit of a failing group is the parity bit, the information bits are output unchanged and `dec_out_fixed` is 1.
- R8: The first information bit of a group is valid in the cycle after the group's last input is sampled. The remaining bits follow in consecutive cycles, and `dec_out_last` marks the `N1`-th bit.
- R9: Cycles with `dec_in_valid` low have no effect on the result. A new group may start in the cycle right after the previous one ends, while that group is still being output.
- R10: Reset discards any partly received group in both directions and drives every valid and strobe output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_in_valid | input | 1 | Information bit present |
| enc_in_bit | input | 1 | Information bit to protect |
| enc_out_valid | output | 1 | Forwarded information bit present |
| enc_out_bit | output | 1 | Forwarded information bit |
| enc_par_valid | output | 1 | Parity bit of the finished group present |
| enc_par_bit | output | 1 | Even-parity bit of the finished group |
| dec_in_valid | input | 1 | Decoded bit and checksum present |
| dec_in_bit | input | 1 | Hard decision from the inner decoder |
| dec_in_csum | input | CSW | Signed checksum of that decision |
| dec_out_valid | output | 1 | Corrected information bit present |
| dec_out_bit | output | 1 | Corrected information bit |
| dec_out_last | output | 1 | Last information bit of the group |
| dec_out_fixed | output | 1 | The group failed parity and one bit was inverted |

## Verification
The two functions that can fall in the same cycle are taking in the first bits of a new group and streaming out the corrected bits of the group just closed. The bench provokes this by walking its vector table with no idle cycles between groups, so every group after the first is received while its predecessor drains. Each captured output group is compared with its tabulated expected byte and flag. Separate tests then space the input with idle cycles and reset in the middle of a group, to show that neither changes which bit gets corrected.

// File: rtl/spc_pkg.sv
package spc_pkg;

    typedef enum logic {
        VERDICT_PASS = 1'b0,
        VERDICT_FIX  = 1'b1
    } grp_verdict_e;

endpackage

// File: rtl/spc_encoder.sv
module spc_encoder #(
    parameter int N1 = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_bit,
    output logic out_valid,
    output logic out_bit,
    output logic par_valid,
    output logic par_bit
);
    localparam int CW = $clog2(N1 + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          acc;
        logic          ov;
        logic          ob;
        logic          pv;
        logic          pb;
    } enc_st_t;

    enc_st_t st_d, st_q;
    logic    acc_next;

    always_comb begin
        st_d     = st_q;
        acc_next = st_q.acc ^ in_bit;
        st_d.ov  = in_valid;
        st_d.ob  = in_bit;
        st_d.pv  = 1'b0;
        if (in_valid) begin
            if (st_q.cnt == CW'(N1 - 1)) begin
                st_d.pv  = 1'b1;
                st_d.pb  = acc_next;
                st_d.acc = 1'b0;
                st_d.cnt = '0;
            end else begin
                st_d.acc = acc_next;
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.ov;
    assign out_bit   = st_q.ob;
    assign par_valid = st_q.pv;
    assign par_bit   = st_q.pb;

endmodule

// File: rtl/spc_magnitude.sv
module spc_magnitude #(
    parameter int W = 10
) (
    input  logic [W-1:0] raw,
    output logic [W-1:0] mag
);
    always_comb begin
        if (raw[W-1]) mag = ~raw + 1'b1;
        else          mag = raw;
    end
endmodule

// File: rtl/spc_minpick.sv
module spc_minpick #(
    parameter int W  = 10,
    parameter int IW = 6
) (
    input  logic          first,
    input  logic [W-1:0]  cur_mag,
    input  logic [IW-1:0] cur_idx,
    input  logic [W-1:0]  best_mag,
    input  logic [IW-1:0] best_idx,
    output logic [W-1:0]  sel_mag,
    output logic [IW-1:0] sel_idx
);
    logic take;

    // strict less-than keeps the earlier index on a tie
    assign take    = first || (cur_mag < best_mag);
    assign sel_mag = take ? cur_mag : best_mag;
    assign sel_idx = take ? cur_idx : best_idx;
endmodule

// File: rtl/spc_decoder.sv
module spc_decoder
    import spc_pkg::*;
#(
    parameter int N1  = 50,
    parameter int CSW = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic           in_bit,
    input  logic [CSW-1:0] in_csum,
    output logic           out_valid,
    output logic           out_bit,
    output logic           out_last,
    output logic           out_fixed
);
    localparam int IW = $clog2(N1 + 1);

    typedef struct packed {
        logic [IW-1:0]  idx;
        logic           acc;
        logic [N1-1:0]  grp;
        logic [CSW-1:0] bmag;
        logic [IW-1:0]  bidx;
        logic [N1-1:0]  osh;
        logic [IW-1:0]  ocnt;
        grp_verdict_e   ofix;
    } dec_st_t;

    localparam dec_st_t DEC_RST = '{
        idx: '0, acc: 1'b0, grp: '0, bmag: '0, bidx: '0,
        osh: '0, ocnt: '0, ofix: VERDICT_PASS
    };

    dec_st_t        st_d, st_q;
    logic [CSW-1:0] cur_mag;
    logic [CSW-1:0] sel_mag;
    logic [IW-1:0]  sel_idx;
    logic           fail;
    logic [N1-1:0]  fixed_grp;

    spc_magnitude #(.W(CSW)) u_mag (
        .raw (in_csum),
        .mag (cur_mag)
    );

    spc_minpick #(.W(CSW), .IW(IW)) u_pick (
        .first    (st_q.idx == '0),
        .cur_mag  (cur_mag),
        .cur_idx  (st_q.idx),
        .best_mag (st_q.bmag),
        .best_idx (st_q.bidx),
        .sel_mag  (sel_mag),
        .sel_idx  (sel_idx)
    );

    always_comb begin
        st_d      = st_q;
        fail      = st_q.acc ^ in_bit;
        fixed_grp = st_q.grp;
        for (int k = 0; k < N1; k++) begin
            if (fail && sel_idx == IW'(k)) fixed_grp[k] = ~st_q.grp[k];
        end

        if (st_q.ocnt != '0) begin
            st_d.osh  = st_q.osh >> 1;
            st_d.ocnt = st_q.ocnt - 1'b1;
        end

        if (in_valid) begin
            if (st_q.idx == IW'(N1)) begin
                st_d.osh  = fixed_grp;
                st_d.ocnt = IW'(N1);
                st_d.ofix = fail ? VERDICT_FIX : VERDICT_PASS;
                st_d.idx  = '0;
                st_d.acc  = 1'b0;
            end else begin
                for (int k = 0; k < N1; k++) begin
                    if (st_q.idx == IW'(k)) st_d.grp[k] = in_bit;
                end
                st_d.acc  = fail;
                st_d.idx  = st_q.idx + 1'b1;
                st_d.bmag = sel_mag;
                st_d.bidx = sel_idx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= DEC_RST;
        else        st_q <= st_d;
    end

    assign out_valid = (st_q.ocnt != '0);
    assign out_bit   = st_q.osh[0];
    assign out_last  = (st_q.ocnt == IW'(1));
    assign out_fixed = (st_q.ofix == VERDICT_FIX);

endmodule

// File: rtl/spc_outer_code.sv
module spc_outer_code #(
    parameter int N1  = 50,
    parameter int CSW = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           enc_in_valid,
    input  logic           enc_in_bit,
    output logic           enc_out_valid,
    output logic           enc_out_bit,
    output logic           enc_par_valid,
    output logic           enc_par_bit,
    input  logic           dec_in_valid,
    input  logic           dec_in_bit,
    input  logic [CSW-1:0] dec_in_csum,
    output logic           dec_out_valid,
    output logic           dec_out_bit,
    output logic           dec_out_last,
    output logic           dec_out_fixed
);
    spc_encoder #(.N1(N1)) u_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (enc_in_valid),
        .in_bit    (enc_in_bit),
        .out_valid (enc_out_valid),
        .out_bit   (enc_out_bit),
        .par_valid (enc_par_valid),
        .par_bit   (enc_par_bit)
    );

    spc_decoder #(.N1(N1), .CSW(CSW)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (dec_in_valid),
        .in_bit    (dec_in_bit),
        .in_csum   (dec_in_csum),
        .out_valid (dec_out_valid),
        .out_bit   (dec_out_bit),
        .out_last  (dec_out_last),
        .out_fixed (dec_out_fixed)
    );
endmodule

// File: rtl/spc_outer_code_chk.sv
module spc_outer_code_chk #(
    parameter int N1  = 50,
    parameter int CSW = 10
) (
    input logic           clk,
    input logic           rst_n,
    input logic           enc_in_valid,
    input logic           enc_in_bit,
    input logic           enc_out_valid,
    input logic           enc_out_bit,
    input logic           enc_par_valid,
    input logic           enc_par_bit,
    input logic           dec_in_valid,
    input logic           dec_in_bit,
    input logic [CSW-1:0] dec_in_csum,
    input logic           dec_out_valid,
    input logic           dec_out_bit,
    input logic           dec_out_last,
    input logic           dec_out_fixed
);
    localparam int CW = $clog2(N1 + 1);

    logic [CW-1:0] seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             seen_q <= '0;
        else if (enc_par_valid) seen_q <= '0;
        else if (enc_out_valid) seen_q <= seen_q + 1'b1;
    end

    p_enc_forward_r1: assert property (@(posedge clk) disable iff (!rst_n)
        enc_in_valid |=> (enc_out_valid && enc_out_bit == $past(enc_in_bit)));

    p_par_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        enc_par_valid |-> (enc_out_valid && seen_q == CW'(N1 - 1)));

    p_fix_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_out_valid && !dec_out_last) |=> $stable(dec_out_fixed));

    p_last_in_burst_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dec_out_last |-> dec_out_valid);

    p_burst_unbroken_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_out_valid && !dec_out_last) |=> dec_out_valid);

    p_reset_quiet_r10: assert property (@(posedge clk)
        !rst_n |-> (!dec_out_valid && !enc_out_valid && !enc_par_valid));
endmodule

bind spc_outer_code spc_outer_code_chk #(.N1(N1), .CSW(CSW)) u_chk (.*);

// File: tb/tb_spc_outer_code.sv
module tb_spc_outer_code;
    localparam int N1  = 8;
    localparam int CSW = 10;

    typedef struct packed {
        logic [8:0]        data;
        logic [3:0]        ia;
        logic signed [9:0] va;
        logic [3:0]        ib;
        logic signed [9:0] vb;
        logic [7:0]        eout;
        logic              efix;
    } vec_t;

    // index 8 is the parity bit; unlisted bits: even +200, odd -300
    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{9'h000, 4'd3, 10'sd5,    4'd9, 10'sd0,   8'h00, 1'b0}, // R3 pass
        '{9'h0FF, 4'd0, 10'sd1,    4'd2, 10'sd1,   8'hFF, 1'b0}, // R3 pass, weak bits kept
        '{9'h001, 4'd5, -10'sd7,   4'd2, 10'sd50,  8'h21, 1'b1}, // R4 negative weakest
        '{9'h007, 4'd6, -10'sd4,   4'd3, 10'sd4,   8'h0F, 1'b1}, // R6 tie -> index 3
        '{9'h100, 4'd8, 10'sd0,    4'd1, 10'sd3,   8'h00, 1'b1}, // R7 parity bit weakest
        '{9'h0AB, 4'd4, -10'sd512, 4'd7, 10'sd511, 8'hAA, 1'b1}, // R5 -512 is strongest
        '{9'h1FE, 4'd1, 10'sd2,    4'd9, 10'sd0,   8'hFE, 1'b0}  // R3 pass
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enc_in_valid = 1'b0, enc_in_bit = 1'b0;
    logic enc_out_valid, enc_out_bit, enc_par_valid, enc_par_bit;
    logic dec_in_valid = 1'b0, dec_in_bit = 1'b0;
    logic [CSW-1:0] dec_in_csum = '0;
    logic dec_out_valid, dec_out_bit, dec_out_last, dec_out_fixed;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    logic [7:0] cap_out [32];
    logic       cap_fix [32];
    int         ngrp = 0, pos = 0, bad_shape = 0;
    logic [7:0] cur = '0;

    always #2 clk = ~clk;

    spc_outer_code #(.N1(N1), .CSW(CSW)) dut (.*);

    always @(negedge clk) begin
        if (!rst_n) begin
            pos = 0; cur = '0;
        end else if (dec_out_valid) begin
            cur[pos] = dec_out_bit;
            if (dec_out_last) begin
                if (pos != 7) bad_shape++;
                cap_out[ngrp % 32] = cur;
                cap_fix[ngrp % 32] = dec_out_fixed;
                ngrp++; pos = 0; cur = '0;
            end else pos++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [CSW-1:0] csum_of(vec_t v, int i);
        if (i == int'(v.ia)) return v.va;
        if (i == int'(v.ib)) return v.vb;
        return (i % 2 == 0) ? 10'sd200 : -10'sd300;
    endfunction

    task automatic send_group(vec_t v, int gap);
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            dec_in_valid = 1'b1; dec_in_bit = v.data[i]; dec_in_csum = csum_of(v, i);
            if (gap > 0 && i < 8) begin
                @(negedge clk);
                dec_in_valid = 1'b0; dec_in_bit = ~dec_in_bit; dec_in_csum = '0;
                repeat (gap - 1) @(negedge clk);
            end
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R8 watchdog actual=running expected=done");
        summary();
    end

    initial begin
        int g0;
        vec_t v;
        logic [7:0] eb [2];
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 dec_out_valid in reset", dec_out_valid, 0);
        check("R10 enc strobes in reset", {enc_out_valid, enc_par_valid}, 0);
        rst_n = 1'b1;

        // table walk, groups back to back (R9 overlap)
        g0 = ngrp;
        for (int k = 0; k < NV; k++) send_group(VECS[k], 0);
        @(negedge clk); dec_in_valid = 1'b0;
        repeat (12) @(negedge clk);
        check("R8 group count", ngrp - g0, NV);
        for (int k = 0; k < NV; k++) begin
            check(VECS[k].efix ? "R4 table data" : "R3 table data",
                  cap_out[(g0 + k) % 32], VECS[k].eout);
            check(VECS[k].efix ? "R4 table flag" : "R3 table flag",
                  cap_fix[(g0 + k) % 32], VECS[k].efix);
        end
        check("R8 last on eighth bit", bad_shape, 0);

        // R8 latency: output valid exactly one cycle after last input
        v = VECS[2];
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            dec_in_valid = 1'b1; dec_in_bit = v.data[i]; dec_in_csum = csum_of(v, i);
            if (i == 8) check("R8 idle before close", dec_out_valid, 0);
        end
        @(negedge clk); dec_in_valid = 1'b0;
        check("R8 first bit valid", dec_out_valid, 1);
        check("R8 first bit value", dec_out_bit, 1);
        repeat (10) @(negedge clk);

        // R9 idle cycles between input bits change nothing
        g0 = ngrp;
        send_group(VECS[3], 2);
        @(negedge clk); dec_in_valid = 1'b0;
        repeat (10) @(negedge clk);
        check("R9 gapped data", cap_out[g0 % 32], 8'h0F);
        check("R9 gapped flag", cap_fix[g0 % 32], 1);

        // R10 reset mid-group discards partial input
        send_group(VECS[0], 0);  // placeholder full group to settle
        @(negedge clk); dec_in_valid = 1'b0;
        repeat (10) @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); dec_in_valid = 1'b1; dec_in_bit = 1'b1; dec_in_csum = 10'sd1;
        end
        @(negedge clk); dec_in_valid = 1'b0; rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        g0 = ngrp;
        v = '{9'h0C3, 4'd9, 10'sd0, 4'd9, 10'sd0, 8'hC3, 1'b0};
        send_group(v, 0);
        @(negedge clk); dec_in_valid = 1'b0;
        repeat (10) @(negedge clk);
        check("R10 one group after reset", ngrp - g0, 1);
        check("R10 realigned data", cap_out[g0 % 32], 8'hC3);

        // R1/R2 encoder: 0xB5 (parity 1) then 0x3C (parity 0)
        eb[0] = 8'hB5; eb[1] = 8'h3C;
        for (int g = 0; g < 2; g++) begin
            for (int i = 0; i < 8; i++) begin
                @(negedge clk);
                enc_in_valid = 1'b1; enc_in_bit = eb[g][i];
                if (g == 1 && i == 0) begin
                    check("R2 parity of first group", {enc_par_valid, enc_par_bit}, 2'b11);
                end
                if (g > 0 || i > 0) begin
                    check("R1 forwarded bit",
                          {enc_out_valid, enc_out_bit}, {1'b1, (i == 0) ? eb[0][7] : eb[g][i-1]});
                    if (i > 0) check("R2 no parity mid-group", enc_par_valid, 0);
                end
            end
        end
        @(negedge clk); enc_in_valid = 1'b0;
        check("R1 last forwarded bit", {enc_out_valid, enc_out_bit}, {1'b1, eb[1][7]});
        check("R2 parity of second group", {enc_par_valid, enc_par_bit}, 2'b10);
        @(negedge clk);
        check("R1 idle after stream", enc_out_valid, 0);

        summary();
    end
endmodule